// File: doc/BRIEF.md
# Two-Wire Command Parser for a Digital Wiper

This block is the slave side of a two-wire open-drain serial link. It drives a 10-bit wiper register and four 10-bit data registers that live in a separate register bank. The block samples the clock and data lines with a fast system clock. A two-flop synchronizer and a short glitch filter clean each line. From the cleaned lines the block detects start and stop conditions and frames bytes on clock edges. It acknowledges the bytes it accepts and transmits read data by pulling the data line low through an output enable.

A frame opens with an address byte. This byte holds a fixed four-bit type code, three bits that must equal the strap pins, and a read/write bit. A command byte follows, carrying an opcode and a two-bit register pointer. Together with the read/write bit, the command selects one of six operations. Two of them are transfers that end after the command byte. The other four move a 10-bit value in two data bytes. Reads take their value from the bank through a select and value port. Writes and transfers reach the bank as a single-cycle command pulse, and only after a stop closes a complete frame.

Top module: `twowire_cmd_slave`

## Requirements
- R1: After reset, and in any frame state other than active, the block leaves `sda_oe` low. Traffic that arrives before the first start condition (data falling while clock is high) is never acknowledged. A start condition always releases the data line.
- R2: Received bits are taken on the rising edge of the clock line. `sda_oe` changes only while the filtered clock line is low, except when a start or stop forces a release.
- R3: The address byte, MSB first, is type code 0101, then three address bits, then the read/write bit (1 = read). It is acknowledged only when the type code matches and the three bits equal `addr_pins`. Otherwise no byte of that frame is acknowledged.
- R4: The command byte, MSB first, is opcode[2:0], a zero, pointer[1:0], and two zeros. A command byte with any of those three reserved bits set is not acknowledged.
- R5: The accepted combinations are the following. Opcode 100 with read/write 1 reads the wiper. Opcode 101 writes the wiper (read/write 0) or reads a data register (1). Opcode 110 writes a data register (0) or transfers a data register into the wiper (1). Opcode 111 with read/write 0 transfers the wiper into a data register. Every other combination is refused without an acknowledge.
- R6: Each accepted byte the master sends (address, command, each write data byte) is acknowledged by pulling data low during the ninth clock. The line is released after that clock falls.
- R7: For writes, bits 1:0 of the first data byte are value bits 9:8 and the upper six bits are ignored. The second data byte is value bits 7:0.
- R8: For reads, `rd_wiper` (1 = wiper) and `rd_ptr` select the source and `rd_value` is captured after the command acknowledge. The block sends six zeros and then value bits 9:8, followed by value bits 7:0, MSB first. It releases the line during each master acknowledge slot.
- R9: If the master does not acknowledge the first read byte, the block drives nothing more until the next start.
- R10: A write or transfer produces exactly one `cmd_valid` pulse, in the cycle after the stop is seen, and only if every byte of the frame completed. `cmd_op` is 0 for a wiper write, 1 for a data register write, 2 for a data register to wiper transfer and 3 for a wiper to data register transfer. `cmd_ptr` is the pointer and `cmd_value` is the write value.
- R11: A frame cut short by a repeated start or by a stop issues nothing.
- R12: A pulse on the clock line shorter than the filter length is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_pins | input | 3 | Strapped low address bits |
| rd_wiper | output | 1 | Read source: 1 wiper, 0 data register |
| rd_ptr | output | 2 | Data register selected for a read |
| rd_value | input | 10 | Value returned by the bank for the current select |
| cmd_valid | output | 1 | Single-cycle command pulse |
| cmd_op | output | 2 | Command code (see R10) |
| cmd_ptr | output | 2 | Data register pointer of the command |
| cmd_value | output | 10 | Write value of the command |

## Verification
The assertions watch several rules on every cycle. The data-line enable only moves while the filtered clock is low, and a start always releases it. Nothing is driven outside an active frame. The bit counter stays within the nine clocks of a byte. Commands appear only as single pulses right after a stop. Address and command decoding, the split of the value across two data bytes, read data ordering, behaviour after a master refusal, dropping of cut-short frames and glitch rejection can only be shown by the bench's bus scenarios. There, a behavioural register bank and a queue of expected commands give the reference.

// File: rtl/twc_pkg.sv
package twc_pkg;

  typedef enum logic [2:0] {
    K_NONE,
    K_RD_WIPER,
    K_WR_WIPER,
    K_RD_REG,
    K_WR_REG,
    K_REG_TO_WIPER,
    K_WIPER_TO_REG
  } cmd_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACTIVE,
    ST_SKIP,
    ST_DONE
  } frame_st_e;

  // Address byte check: type nibble, strap bits, R/W bit ignored here.
  function automatic logic addr_match(input logic [7:0] b, input logic [3:0] dev_type,
                                      input logic [2:0] pins);
    return (b[7:4] == dev_type) && (b[3:1] == pins);
  endfunction

  // Command byte plus R/W bit to operation kind.
  function automatic cmd_kind_e decode_cmd(input logic rw, input logic [7:0] b);
    cmd_kind_e k;
    k = K_NONE;
    if (!(b[4] | b[1] | b[0])) begin
      case ({b[7:5], rw})
        4'b100_1: k = K_RD_WIPER;
        4'b101_0: k = K_WR_WIPER;
        4'b101_1: k = K_RD_REG;
        4'b110_0: k = K_WR_REG;
        4'b110_1: k = K_REG_TO_WIPER;
        4'b111_0: k = K_WIPER_TO_REG;
        default:  k = K_NONE;
      endcase
    end
    return k;
  endfunction

  function automatic logic is_read(input cmd_kind_e k);
    return (k == K_RD_WIPER) || (k == K_RD_REG);
  endfunction

  function automatic logic is_two_byte(input cmd_kind_e k);
    return (k == K_REG_TO_WIPER) || (k == K_WIPER_TO_REG);
  endfunction

  function automatic logic is_issued(input cmd_kind_e k);
    return (k == K_WR_WIPER) || (k == K_WR_REG) || is_two_byte(k);
  endfunction

  function automatic logic [1:0] issue_code(input cmd_kind_e k);
    case (k)
      K_WR_WIPER:     return 2'd0;
      K_WR_REG:       return 2'd1;
      K_REG_TO_WIPER: return 2'd2;
      default:        return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/twc_line_filter.sv
module twc_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] != out_q) begin
        if (cnt_q == CW'(FILT_LEN - 1)) begin
          out_q <= sync_q[1];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign line_o = out_q;
endmodule

// File: rtl/twc_bus_events.sv
module twc_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_p;
  assign scl_fall  = ~scl_f & scl_p;
  assign start_evt = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_evt  = scl_f & scl_p & ~sda_p & sda_f;
endmodule

// File: rtl/twc_frame_engine.sv
module twc_frame_engine
  import twc_pkg::*;
#(
  parameter int         DATA_W   = 10,
  parameter logic [3:0] DEV_TYPE = 4'b0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_f,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [2:0]        addr_pins,
  input  logic [DATA_W-1:0] rd_value,
  output logic              sda_oe,
  output logic              rd_wiper,
  output logic [1:0]        rd_ptr,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [1:0]        cmd_ptr,
  output logic [DATA_W-1:0] cmd_value,
  output logic              busy,
  output logic [3:0]        bit_cnt
);
  localparam int HI_W = DATA_W - 8;

  frame_st_e         st_q;
  cmd_kind_e         kind_q;
  cmd_kind_e         kind_rx;
  logic [3:0]        bit_cnt_q;
  logic [1:0]        byte_idx_q;
  logic [7:0]        shreg_q;
  logic              rw_q;
  logic [1:0]        ptr_q;
  logic [HI_W-1:0]   hi_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] txword_q;
  logic              txmode_q;
  logic              mack_q;
  logic              oe_q;
  logic              byte_ok;
  logic              frame_end;
  logic [7:0]        tx_byte;
  logic              cmd_valid_q;
  logic [1:0]        cmd_op_q, cmd_ptr_q;
  logic [DATA_W-1:0] cmd_value_q;

  assign kind_rx   = decode_cmd(rw_q, shreg_q);
  assign frame_end = ((byte_idx_q == 2'd1) && is_two_byte(kind_q)) || (byte_idx_q == 2'd3);
  assign tx_byte   = (byte_idx_q == 2'd2) ? {{(8-HI_W){1'b0}}, txword_q[DATA_W-1:8]}
                                          : txword_q[7:0];

  always_comb begin
    case (byte_idx_q)
      2'd0:    byte_ok = addr_match(shreg_q, DEV_TYPE, addr_pins);
      2'd1:    byte_ok = (kind_rx != K_NONE);
      default: byte_ok = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      kind_q     <= K_NONE;
      bit_cnt_q  <= '0;
      byte_idx_q <= '0;
      shreg_q    <= '0;
      rw_q       <= 1'b0;
      ptr_q      <= '0;
      hi_q       <= '0;
      data_q     <= '0;
      txword_q   <= '0;
      txmode_q   <= 1'b0;
      mack_q     <= 1'b1;
      oe_q       <= 1'b0;
    end else if (start_evt) begin
      st_q       <= ST_ACTIVE;
      kind_q     <= K_NONE;
      bit_cnt_q  <= '0;
      byte_idx_q <= '0;
      txmode_q   <= 1'b0;
      oe_q       <= 1'b0;
    end else if (stop_evt) begin
      st_q     <= ST_IDLE;
      txmode_q <= 1'b0;
      oe_q     <= 1'b0;
    end else if (st_q == ST_ACTIVE) begin
      if (scl_rise) begin
        if (bit_cnt_q < 4'd8) begin
          if (!txmode_q) shreg_q <= {shreg_q[6:0], sda_f};
          bit_cnt_q <= bit_cnt_q + 4'd1;
        end else if (bit_cnt_q == 4'd8) begin
          mack_q    <= sda_f;
          bit_cnt_q <= 4'd9;
        end
      end else if (scl_fall) begin
        if (bit_cnt_q == 4'd8) begin
          if (txmode_q) begin
            oe_q <= 1'b0;
          end else if (byte_ok) begin
            oe_q <= 1'b1;
            case (byte_idx_q)
              2'd0: rw_q <= shreg_q[0];
              2'd1: begin
                kind_q <= kind_rx;
                ptr_q  <= shreg_q[3:2];
              end
              2'd2:    hi_q   <= shreg_q[HI_W-1:0];
              default: data_q <= {hi_q, shreg_q};
            endcase
          end else begin
            st_q <= ST_SKIP;
            oe_q <= 1'b0;
          end
        end else if (bit_cnt_q == 4'd9) begin
          bit_cnt_q  <= '0;
          byte_idx_q <= byte_idx_q + 2'd1;
          if (txmode_q && mack_q) begin
            st_q     <= ST_SKIP;
            txmode_q <= 1'b0;
            oe_q     <= 1'b0;
          end else if (frame_end) begin
            st_q     <= ST_DONE;
            txmode_q <= 1'b0;
            oe_q     <= 1'b0;
          end else if (is_read(kind_q)) begin
            txmode_q <= 1'b1;
            if (byte_idx_q == 2'd1) begin
              txword_q <= rd_value;
              oe_q     <= 1'b1;
            end else begin
              oe_q <= ~txword_q[7];
            end
          end else begin
            txmode_q <= 1'b0;
            oe_q     <= 1'b0;
          end
        end else if (txmode_q && (bit_cnt_q != 4'd0)) begin
          oe_q <= ~tx_byte[3'd7 - bit_cnt_q[2:0]];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid_q <= 1'b0;
      cmd_op_q    <= '0;
      cmd_ptr_q   <= '0;
      cmd_value_q <= '0;
    end else begin
      cmd_valid_q <= stop_evt && !start_evt && (st_q == ST_DONE) && is_issued(kind_q);
      if (stop_evt && (st_q == ST_DONE) && is_issued(kind_q)) begin
        cmd_op_q    <= issue_code(kind_q);
        cmd_ptr_q   <= ptr_q;
        cmd_value_q <= data_q;
      end
    end
  end

  assign sda_oe    = oe_q;
  assign rd_wiper  = (kind_q == K_RD_WIPER);
  assign rd_ptr    = ptr_q;
  assign cmd_valid = cmd_valid_q;
  assign cmd_op    = cmd_op_q;
  assign cmd_ptr   = cmd_ptr_q;
  assign cmd_value = cmd_value_q;
  assign busy      = (st_q != ST_IDLE);
  assign bit_cnt   = bit_cnt_q;
endmodule

// File: rtl/twowire_cmd_slave.sv
module twowire_cmd_slave #(
  parameter int         FILT_LEN = 3,
  parameter int         DATA_W   = 10,
  parameter logic [3:0] DEV_TYPE = 4'b0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        addr_pins,
  output logic              rd_wiper,
  output logic [1:0]        rd_ptr,
  input  logic [DATA_W-1:0] rd_value,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [1:0]        cmd_ptr,
  output logic [DATA_W-1:0] cmd_value
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_lines;
  logic [N_LINES-1:0] clean_lines;
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_evt, stop_evt;
  logic busy;
  logic [3:0] bit_cnt;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_filt
    twc_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .line_i(raw_lines[g]),
      .line_o(clean_lines[g])
    );
  end

  assign scl_f = clean_lines[0];
  assign sda_f = clean_lines[1];

  twc_bus_events u_events (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .sda_f    (sda_f),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
  );

  twc_frame_engine #(.DATA_W(DATA_W), .DEV_TYPE(DEV_TYPE)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_f    (sda_f),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .addr_pins(addr_pins),
    .rd_value (rd_value),
    .sda_oe   (sda_oe),
    .rd_wiper (rd_wiper),
    .rd_ptr   (rd_ptr),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_ptr  (cmd_ptr),
    .cmd_value(cmd_value),
    .busy     (busy),
    .bit_cnt  (bit_cnt)
  );
endmodule

// File: rtl/twc_checker.sv
module twc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_f,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       busy,
  input logic [3:0] bit_cnt,
  input logic       sda_oe,
  input logic       cmd_valid
);
  AST_RELEASE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe); // R1

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sda_oe); // R1

  AST_DRIVE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_evt) && !$past(stop_evt)) |-> !scl_f); // R2

  AST_BIT_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= 4'd9); // R6

  AST_CMD_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(stop_evt)); // R10

  AST_CMD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R10
endmodule

bind twowire_cmd_slave twc_checker u_twc_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_f    (scl_f),
  .start_evt(start_evt),
  .stop_evt (stop_evt),
  .busy     (busy),
  .bit_cnt  (bit_cnt),
  .sda_oe   (sda_oe),
  .cmd_valid(cmd_valid)
);

// File: tb/twowire_cmd_slave_bench.sv
module twowire_cmd_slave_bench;
  localparam logic [2:0] PINS = 3'b110;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, rd_wiper, cmd_valid;
  logic [1:0] rd_ptr, cmd_op, cmd_ptr;
  logic [9:0] rd_value, cmd_value;
  logic sda_line;

  // behavioural register bank and expected command queue
  logic [9:0] wiper_m = '0;
  logic [9:0] dr_m [0:3] = '{default: '0};
  logic [13:0] exp_q [$];
  logic [13:0] exp_e;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit stable_err = 0;
  bit glitch_arm = 0;
  bit last_slot = 0;

  assign sda_line = sda_m & ~sda_oe;
  assign rd_value = rd_wiper ? wiper_m : dr_m[rd_ptr];

  twowire_cmd_slave u_twowire_cmd_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_pins(PINS), .rd_wiper(rd_wiper), .rd_ptr(rd_ptr), .rd_value(rd_value),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ptr(cmd_ptr), .cmd_value(cmd_value)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // reference: command pulses compared against the queue on every clock
  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R10 unexpected command actual=%0h expected=none", {cmd_op, cmd_ptr, cmd_value});
      end else begin
        exp_e = exp_q.pop_front();
        if (cmd_op != exp_e[13:12] || cmd_ptr != exp_e[11:10] ||
            (exp_e[13:12] < 2'd2 && cmd_value != exp_e[9:0])) begin
          n_fail++;
          $display("FAIL R10 command fields actual=%0h expected=%0h", {cmd_op, cmd_ptr, cmd_value}, exp_e);
        end
        case (exp_e[13:12])
          2'd0: wiper_m = exp_e[9:0];
          2'd1: dr_m[exp_e[11:10]] = exp_e[9:0];
          2'd2: wiper_m = dr_m[exp_e[11:10]];
          default: dr_m[exp_e[11:10]] = wiper_m;
        endcase
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic bit exp_cmd_ok(input bit rw, input logic [7:0] b);
    if (b[4] || b[1] || b[0]) return 0;
    if (rw) return (b[7:5] >= 3'd4) && (b[7:5] <= 3'd6);
    return b[7:5] >= 3'd5;
  endfunction

  task automatic clk_bit(input bit b, output bit r);
    bit r2;
    tick(4);
    sda_m = b;
    if (glitch_arm) begin
      glitch_arm = 0;
      tick(2); scl_m = 1'b1; tick(1); scl_m = 1'b0; tick(13);
    end else begin
      tick(16);
    end
    scl_m = 1'b1;
    tick(10);
    r = sda_line;
    tick(8);
    r2 = sda_line;
    if (r != r2) stable_err = 1;
    tick(2);
    scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ackb);
    bit r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, ackb);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    bit r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      b[i] = r;
    end
    clk_bit(mack, r);
    last_slot = r;
  endtask

  task automatic bus_start;
    tick(10); sda_m = 1'b1; tick(10); scl_m = 1'b1; tick(20);
    sda_m = 1'b0; tick(20); scl_m = 1'b0;
    stable_err = 0;
  endtask

  task automatic bus_stop;
    tick(10); sda_m = 1'b0; tick(10); scl_m = 1'b1; tick(20);
    sda_m = 1'b1; tick(20);
  endtask

  task automatic no_cmd_after(input string req);
    tick(30);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic do_write(input logic [2:0] op, input logic [1:0] ptr, input logic [9:0] v,
                          input logic [5:0] junk, input logic [1:0] code);
    bit a;
    bus_start;
    send_byte({4'b0101, PINS, 1'b0}, a); chk(a == 0, "R3 address ack", a, 0);
    send_byte({op, 1'b0, ptr, 2'b00}, a); chk(a == 0, "R4 command ack", a, 0);
    send_byte({junk, v[9:8]}, a);        chk(a == 0, "R6 data byte 1 ack", a, 0);
    send_byte(v[7:0], a);                chk(a == 0, "R6 data byte 2 ack", a, 0);
    chk(stable_err == 0, "R2 data stable while clock high", stable_err, 0);
    exp_q.push_back({code, ptr, v});
    bus_stop;
    no_cmd_after("R10 command issued after stop");
  endtask

  task automatic do_read(input logic [2:0] op, input logic [1:0] ptr, input logic [9:0] expv,
                         input string req);
    bit a;
    logic [7:0] hi, lo;
    bus_start;
    send_byte({4'b0101, PINS, 1'b1}, a); chk(a == 0, "R3 address ack (read)", a, 0);
    send_byte({op, 1'b0, ptr, 2'b00}, a); chk(a == 0, "R5 read command ack", a, 0);
    recv_byte(1'b0, hi);
    recv_byte(1'b1, lo);
    chk(hi == {6'b0, expv[9:8]}, req, hi, {6'b0, expv[9:8]});
    chk(lo == expv[7:0], req, lo, expv[7:0]);
    chk(last_slot == 1'b1, "R8 released in master ack slot", last_slot, 1);
    chk(stable_err == 0, "R2 read data stable while clock high", stable_err, 0);
    bus_stop;
    no_cmd_after("R10 read issues no command");
  endtask

  task automatic do_xfer(input bit rw, input logic [2:0] op, input logic [1:0] ptr,
                         input logic [1:0] code);
    bit a;
    bus_start;
    send_byte({4'b0101, PINS, rw}, a); chk(a == 0, "R3 address ack (transfer)", a, 0);
    send_byte({op, 1'b0, ptr, 2'b00}, a); chk(a == 0, "R5 transfer command ack", a, 0);
    exp_q.push_back({code, ptr, 10'd0});
    bus_stop;
    no_cmd_after("R5 transfer issued after stop");
  endtask

  task automatic do_reject_addr(input logic [7:0] ab);
    bit a;
    bus_start;
    send_byte(ab, a); chk(a == 1, "R3 mismatched address not acked", a, 1);
    send_byte(8'hA0, a); chk(a == 1, "R3 no response after mismatch", a, 1);
    bus_stop;
    no_cmd_after("R3 no command after mismatch");
  endtask

  task automatic do_reject_cmd(input bit rw, input logic [7:0] cb, input string req);
    bit a;
    bus_start;
    send_byte({4'b0101, PINS, rw}, a); chk(a == 0, "R3 address ack", a, 0);
    send_byte(cb, a);
    chk(a == !exp_cmd_ok(rw, cb), req, a, !exp_cmd_ok(rw, cb));
    send_byte(8'h03, a); chk(a == 1, req, a, 1);
    bus_stop;
    no_cmd_after(req);
  endtask

  initial begin
    bit a;
    logic [7:0] rb;
    tick(5);
    chk(sda_oe == 0, "R1 reset releases data line", sda_oe, 0);
    chk(cmd_valid == 0, "R10 no command in reset", cmd_valid, 0);
    rst_n = 1'b1;
    tick(20);

    // R1: a matching address byte without a start is ignored
    scl_m = 1'b0;
    send_byte({4'b0101, PINS, 1'b0}, a);
    chk(a == 1, "R1 no ack before start", a, 1);
    bus_stop;
    no_cmd_after("R1 nothing issued before start");

    // R7: upper six bits of first data byte ignored
    do_write(3'b101, 2'd0, 10'h2A5, 6'b111111, 2'd0);
    do_read(3'b100, 2'd0, 10'h2A5, "R7 wiper value read back");
    do_write(3'b110, 2'd2, 10'h155, 6'b101010, 2'd1);
    do_read(3'b101, 2'd2, 10'h155, "R8 data register 2 read");

    // R12: short clock glitch during the address byte
    glitch_arm = 1;
    do_write(3'b110, 2'd1, 10'h3C3, 6'b000111, 2'd1);
    do_read(3'b101, 2'd1, 10'h3C3, "R12 write under glitch");

    do_xfer(1'b1, 3'b110, 2'd1, 2'd2);
    do_read(3'b100, 2'd0, 10'h3C3, "R5 register to wiper transfer");
    do_xfer(1'b0, 3'b111, 2'd3, 2'd3);
    do_read(3'b101, 2'd3, 10'h3C3, "R5 wiper to register transfer");

    do_reject_addr({4'b0101, 3'b010, 1'b0});
    do_reject_addr({4'b0110, PINS, 1'b0});
    do_reject_cmd(1'b0, 8'b100_0_00_00, "R5 read-wiper opcode with write bit refused");
    do_reject_cmd(1'b1, 8'b111_0_10_00, "R5 wiper-to-register opcode with read bit refused");
    do_reject_cmd(1'b0, 8'b101_1_00_00, "R4 reserved command bit refused");
    do_reject_cmd(1'b0, 8'b110_0_01_01, "R4 reserved low command bits refused");

    // R11: frame cut by repeated start, then a full transfer frame
    bus_start;
    send_byte({4'b0101, PINS, 1'b0}, a);
    send_byte(8'b110_0_00_00, a);
    send_byte(8'h03, a); chk(a == 0, "R6 partial frame data ack", a, 0);
    bus_start;
    send_byte({4'b0101, PINS, 1'b0}, a);
    send_byte(8'b111_0_11_00, a); chk(a == 0, "R11 command after repeated start", a, 0);
    exp_q.push_back({2'd3, 2'd3, 10'd0});
    bus_stop;
    no_cmd_after("R11 only the completed frame issues");
    do_read(3'b101, 2'd0, 10'h000, "R11 cut frame left register 0 alone");

    // R11: frame cut by a stop
    bus_start;
    send_byte({4'b0101, PINS, 1'b0}, a);
    send_byte(8'b101_0_00_00, a);
    send_byte(8'h01, a);
    bus_stop;
    no_cmd_after("R11 frame cut by stop issues nothing");
    do_read(3'b100, 2'd0, 10'h3C3, "R11 wiper unchanged after cut frame");

    // R9: master refuses first read byte
    bus_start;
    send_byte({4'b0101, PINS, 1'b1}, a);
    send_byte(8'b101_0_10_00, a);
    recv_byte(1'b1, rb);
    chk(rb == 8'h01, "R8 high read byte", rb, 8'h01);
    recv_byte(1'b1, rb);
    chk(rb == 8'hFF, "R9 released after master refusal", rb, 8'hFF);
    bus_stop;
    no_cmd_after("R9 no command after refused read");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule